// File: doc/BRIEF.md
# Slow-Strobe Trigger Handoff

This block lives entirely in a fast system clock domain and hands a one-cycle request from fast-side logic to the output stage of a character LCD. The LCD is paced by a much slower strobe, nominally 200 kHz against a 48 MHz system clock. The two share a frequency lock but have no fixed phase relation. The block does not clock anything from the strobe. It treats the strobe as data: a chain of flip-flops on the fast clock samples it, and the block looks for a high-to-low change between successive samples.

A request marks a trigger as pending. The trigger stays pending until the next detected falling edge of the strobe retires it. At that point the block emits a single-cycle transfer pulse, which the LCD output logic uses in the fast domain. Several requests that arrive before the strobe falls are merged into one trigger. If a request lands in the same cycle as a detected edge, the request wins, and the trigger stays pending for the following edge.

Top module: `slow_trig_handoff`

## Requirements
- R1: The asynchronous active-high reset `rst` clears the pending flag and the transfer pulse at once, and it also clears every strobe sampling flip-flop.
- R2: When `req_i` is high at a rising clock edge, `pending_o` is high after that edge.
- R3: A pending trigger stays pending through rising strobe edges and through any interval in which the strobe does not fall.
- R4: When the strobe goes low while a trigger is pending, `xfer_o` rises on the third rising clock edge that samples the strobe low. This is two to three cycles after the physical edge, allowing for two synchronizer stages and the edge register.
- R5: `xfer_o` is high for exactly one cycle. `pending_o` falls on the same edge that raises `xfer_o`, unless R8 applies.
- R6: A falling strobe edge that finds no trigger pending produces no pulse.
- R7: Any number of requests before one strobe falling edge yield a single pulse.
- R8: A request sampled on the same edge as a detected falling edge leaves `pending_o` high. A pulse is still issued if a trigger was already pending before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Asynchronous reset, active high |
| strobe_i | input | 1 | Slow LCD strobe, sampled as data |
| req_i | input | 1 | One-cycle trigger request from fast logic |
| pending_o | output | 1 | A trigger is waiting for a strobe falling edge |
| xfer_o | output | 1 | One-cycle transfer pulse |

## Verification
The assertions assume that `req_i` and `rst` are clean synchronous signals in the fast domain. The strobe may change at any time, because only the synchronizer looks at it. The single-cycle pulse property also relies on each strobe falling edge being detected only once. That holds whenever the strobe stays low for at least one sampled cycle, and the stimulus always holds it low for many. The bench changes every input at the falling clock edge, far from the sampling edge. It shifts the strobe edges by a random number of whole cycles, and in the free-running phase it keeps a 240-cycle strobe period.

// File: rtl/slow_trig_pkg.sv
package slow_trig_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic pending;
    logic xfer;
  } trig_state_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or posedge rst) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or posedge rst) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[LAST];
endmodule

// File: rtl/fall_detect.sv
module fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic smp_i,
  output logic fall_o
);
  logic older;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) older <= 1'b0;
    else     older <= smp_i;
  end

  assign fall_o = older & ~smp_i;
endmodule

// File: rtl/trig_hold.sv
module trig_hold
  import slow_trig_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic fall_i,
  output logic pending_o,
  output logic xfer_o
);
  trig_state_t st_q, st_d;

  always_comb begin
    st_d.xfer    = fall_i & st_q.pending;
    st_d.pending = st_q.pending;
    if (fall_i) st_d.pending = 1'b0;
    if (req_i)  st_d.pending = 1'b1;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign pending_o = st_q.pending;
  assign xfer_o    = st_q.xfer;
endmodule

// File: rtl/slow_trig_handoff.sv
module slow_trig_handoff
  import slow_trig_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  input  logic req_i,
  output logic pending_o,
  output logic xfer_o
);
  logic strobe_s;
  logic strobe_fall;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (strobe_i),
    .q_o (strobe_s)
  );

  fall_detect u_fall (
    .clk    (clk),
    .rst    (rst),
    .smp_i  (strobe_s),
    .fall_o (strobe_fall)
  );

  trig_hold u_hold (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .fall_i    (strobe_fall),
    .pending_o (pending_o),
    .xfer_o    (xfer_o)
  );
endmodule

// File: rtl/slow_trig_handoff_chk.sv
module slow_trig_handoff_chk (
  input logic clk,
  input logic rst,
  input logic req_i,
  input logic pending_o,
  input logic xfer_o
);
  assert_req_sets_R2: assert property (@(posedge clk) disable iff (rst)
    req_i |=> pending_o);

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
    xfer_o |=> !xfer_o);

  assert_pulse_needs_pending_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_o) |-> $past(pending_o));

  assert_clear_with_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(pending_o) |-> xfer_o);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |-> (!pending_o && !xfer_o));
endmodule

bind slow_trig_handoff slow_trig_handoff_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_i     (req_i),
  .pending_o (pending_o),
  .xfer_o    (xfer_o)
);

// File: tb/slow_trig_handoff_tb.sv
module slow_trig_handoff_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe_i = 1'b1;
  logic req_i = 1'b0;
  logic pending_o, xfer_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slow_trig_handoff u_dut (
    .clk(clk), .rst(rst), .strobe_i(strobe_i), .req_i(req_i),
    .pending_o(pending_o), .xfer_o(xfer_o)
  );

  // {nreq[3:0], coincident_req, exp_pulses[1:0], exp_pending_after}
  localparam logic [7:0] VEC [8] = '{
    {4'd0, 1'b0, 2'd0, 1'b0},  // R6 idle edge
    {4'd1, 1'b0, 2'd1, 1'b0},  // R4 single request
    {4'd3, 1'b0, 2'd1, 1'b0},  // R7 merged
    {4'd5, 1'b0, 2'd1, 1'b0},  // R7 merged
    {4'd1, 1'b1, 2'd1, 1'b1},  // R8 pending plus coincident request
    {4'd0, 1'b0, 2'd1, 1'b0},  // R8 carried trigger retires
    {4'd0, 1'b1, 2'd0, 1'b1},  // R8 coincident request, nothing pending
    {4'd0, 1'b0, 2'd1, 1'b0}   // R8 carried trigger retires
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit exp_pend;
    ticks(3);
    chk("R1 pending in reset", pending_o, 0);
    chk("R1 xfer in reset", xfer_o, 0);
    rst = 1'b0;
    ticks(6);
    exp_pend = 1'b0;

    for (int v = 0; v < 8; v++) begin
      int nreq, coin, expp, exppend, pulses, first, rise_pulses;
      nreq = int'(VEC[v][7:4]); coin = int'(VEC[v][3]);
      expp = int'(VEC[v][2:1]); exppend = int'(VEC[v][0]);
      for (int r = 0; r < nreq; r++) begin
        req_i = 1'b1; @(negedge clk);
      end
      req_i = 1'b0;
      if (nreq > 0) exp_pend = 1'b1;
      ticks($urandom_range(1, 8));
      chk($sformatf("R2 R3 pending before edge v%0d", v), pending_o, exp_pend);
      strobe_i = 1'b0;
      pulses = 0; first = -1;
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk);
        if (xfer_o) begin
          pulses++;
          if (first < 0) first = k;
        end
        req_i = (coin != 0 && k == 2);
      end
      req_i = 1'b0;
      chk($sformatf("R4 R5 R6 R7 pulse count v%0d", v), pulses, expp);
      if (expp > 0) chk($sformatf("R4 pulse latency v%0d", v), first, 3);
      chk($sformatf("R5 R8 pending after edge v%0d", v), pending_o, exppend);
      exp_pend = exppend[0];
      ticks(4);
      strobe_i = 1'b1;
      rise_pulses = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (xfer_o) rise_pulses++;
      end
      chk($sformatf("R3 rising edge no pulse v%0d", v), rise_pulses, 0);
      chk($sformatf("R3 pending kept over rise v%0d", v), pending_o, exp_pend);
    end

    // free-running strobe, 240-cycle period, random phase
    begin
      int total, expected_total;
      total = 0; expected_total = 0;
      ticks($urandom_range(0, 239));
      for (int p = 0; p < 10; p++) begin
        int rq, lat;
        rq = $urandom_range(10, 100);
        for (int c = 0; c < 120; c++) begin
          req_i = (c == rq);
          @(negedge clk);
          if (xfer_o) total++;
        end
        req_i = 1'b0;
        strobe_i = 1'b0;
        expected_total++;
        lat = -1;
        for (int c = 1; c <= 120; c++) begin
          @(negedge clk);
          if (xfer_o) begin
            total++;
            if (lat < 0) lat = c;
          end
        end
        chk($sformatf("R4 free-run latency p%0d", p), (lat >= 1 && lat <= 3) ? 1 : 0, 1);
        chk($sformatf("R5 free-run cleared p%0d", p), pending_o, 0);
        strobe_i = 1'b1;
      end
      chk("R7 free-run pulse total", total, expected_total);
    end

    // asynchronous reset while pending
    req_i = 1'b1; @(negedge clk); req_i = 1'b0;
    chk("R2 pending before reset", pending_o, 1);
    #2 rst = 1'b1; #1;
    chk("R1 async clear of pending", pending_o, 0);
    @(negedge clk); rst = 1'b0;
    strobe_i = 1'b0;
    begin
      int pulses;
      pulses = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (xfer_o) pulses++;
      end
      chk("R1 R6 no pulse after reset", pulses, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule